// File: doc/BRIEF.md
# Programmable raster sync timing generator

This block produces the sync, blanking and window signals for a raster display from a pixel clock. It has two counters. The horizontal position counts clocks within a line. The vertical position counts lines within a frame. Both counters start at 1. Every signal is a window on one counter or on both. A window is defined by a programmed start value and a programmed end value. A programmed value n places an edge n+1 counts after the start of the line or frame, and the start of the line is where horizontal blank begins.

Software or a sequencer loads the timing values through a parallel write port (address, data, strobe). Timing writes go into a shadow set. The live set takes them over only at the point where one frame ends and the next begins, so no frame is ever drawn with mixed timing.

A configuration word takes effect on the next clock. It selects which of the derived signals reaches each of four output pins, sets the active level of each pin, and gates the counters.

Top module: `rtg_sync_gen`

## Requirements
- R1: `h_pos` counts 1, 2, ... up to the live clocks-per-line value and then returns to 1. `v_pos` steps by one each time `h_pos` returns to 1. `v_pos` returns to 1 after the live lines-per-frame value. Both read 1 after reset.
- R2: A clocks-per-line write with an odd value or zero is dropped. A lines-per-frame write of zero is dropped. In both cases the shadow value stays as it was.
- R3: Horizontal blank is active while `h_pos` <= blank width. Horizontal sync is active while front porch < `h_pos` <= sync end. Vertical blank and vertical sync follow the same rules using `v_pos` and the vertical registers.
- R4: Composite blank is horizontal blank OR vertical blank. Composite sync is horizontal sync OR vertical sync. Both are formed active-high, before polarity is applied.
- R5: The select code (config bits 2:0) routes the signals to the pins:
  - pin A: bit0=0 gives composite blank, bit0=1 gives vertical blank.
  - pin B: bit1=0 gives composite sync, bit1=1 gives vertical sync.
  - pin C: bit0=1 gives horizontal blank. Otherwise it gives the cursor when bit2=1 and the horizontal gate when bit2=0.
  - pin D: bit1=1 gives horizontal sync. Otherwise it gives the vertical interrupt when bit2=1 and the vertical gate when bit2=0.
- R6: Config bits 3, 4, 5 and 6 set the polarity of pins A, B, C and D in that order. A value of 1 drives the selected signal active-high. A value of 0 drives it inverted (active-low).
- R7: Config bit 7 enables the counters. While it is 0, `h_pos`, `v_pos` and the live timing set hold their values.
- R8: The horizontal gate is active while cursor h-start < `h_pos` <= cursor h-end. The vertical gate is active while cursor v-start < `v_pos` <= cursor v-end. The cursor is the AND of the two gates. The vertical interrupt is active while on-line < `v_pos` <= off-line.
- R9: Timing register writes reach the live set only on an enabled clock where `h_pos` and `v_pos` both sit at their live maxima. Config writes take effect on the next clock.
- R10: After reset the config word is 0x80: select 000, all pins active-low, counters enabled. The timing set after reset is:
  - horizontal: front porch 2, sync end 5, blank width 8, 20 clocks per line.
  - vertical: front porch 1, sync end 3, blank width 4, 12 lines per frame.
  - vertical interrupt: on-line 2, off-line 3.
  - cursor: horizontal 10 to 14, vertical 5 to 8.
- R11: The register addresses are:
  - 0: config.
  - 1 to 4: horizontal front porch, sync end, blank width, clocks per line.
  - 5 to 8: the same four for the vertical axis, in lines.
  - 13 and 14: vertical interrupt on-line and off-line.
  - 15 to 18: cursor h-start, h-end, v-start, v-end.
  
  Writes to any other address change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 12 | Register write data |
| pin_a | output | 1 | Blank pin (composite or vertical) |
| pin_b | output | 1 | Sync pin (composite or vertical) |
| pin_c | output | 1 | Horizontal gate, horizontal blank or cursor |
| pin_d | output | 1 | Vertical gate, horizontal sync or vertical interrupt |
| h_pos | output | 12 | Horizontal position, 1-based |
| v_pos | output | 12 | Vertical position, 1-based |

## Verification
The assertions assume that every programmed value fits the counter width. They also assume that software never programs a start beyond an end or a total below an edge time, because the counter checks only hold when the live totals bound the positions. The stimulus keeps every front porch, sync end, blank width and window end at or below the matching total. It lets each new total reach the live set only through the frame boundary. Writes that R2 says to drop are applied deliberately, so the live totals always stay even and nonzero.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    parameter int TW    = 12;
    parameter int AW    = 5;
    parameter int CFG_W = 8;
    parameter int NPIN  = 4;

    typedef logic [TW-1:0] tval_t;

    typedef struct packed {
        tval_t fp;
        tval_t se;
        tval_t bw;
        tval_t tot;
    } axis_t;

    typedef struct packed {
        axis_t h;
        axis_t v;
        tval_t vi_on;
        tval_t vi_off;
        tval_t cur_hs;
        tval_t cur_he;
        tval_t cur_vs;
        tval_t cur_ve;
    } tmg_t;

    typedef struct packed {
        logic            en;
        logic [NPIN-1:0] pol;
        logic [2:0]      sel;
    } cfg_t;

    typedef struct packed {
        logic hblank;
        logic hsync;
        logic vblank;
        logic vsync;
        logic cblank;
        logic csync;
        logic hgate;
        logic vgate;
        logic cursor;
        logic vint;
    } raw_t;

    localparam logic [AW-1:0] ADR_CFG    = 5'd0;
    localparam logic [AW-1:0] ADR_H_FP   = 5'd1;
    localparam logic [AW-1:0] ADR_H_SE   = 5'd2;
    localparam logic [AW-1:0] ADR_H_BW   = 5'd3;
    localparam logic [AW-1:0] ADR_H_TOT  = 5'd4;
    localparam logic [AW-1:0] ADR_V_FP   = 5'd5;
    localparam logic [AW-1:0] ADR_V_SE   = 5'd6;
    localparam logic [AW-1:0] ADR_V_BW   = 5'd7;
    localparam logic [AW-1:0] ADR_V_TOT  = 5'd8;
    localparam logic [AW-1:0] ADR_VI_ON  = 5'd13;
    localparam logic [AW-1:0] ADR_VI_OFF = 5'd14;
    localparam logic [AW-1:0] ADR_CUR_HS = 5'd15;
    localparam logic [AW-1:0] ADR_CUR_HE = 5'd16;
    localparam logic [AW-1:0] ADR_CUR_VS = 5'd17;
    localparam logic [AW-1:0] ADR_CUR_VE = 5'd18;

    // true for start < pos <= stop (edge n lands n+1 counts in)
    function automatic logic in_win(tval_t pos, tval_t start, tval_t stop);
        return (pos > start) && (pos <= stop);
    endfunction

endpackage

// File: rtl/rtg_regs.sv
module rtg_regs
    import rtg_pkg::*;
#(
    parameter tmg_t RST_TMG = '0,
    parameter cfg_t RST_CFG = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [TW-1:0] wr_data,
    input  logic          frame_end,
    output tmg_t          act,
    output cfg_t          cfg
);

    tmg_t pend_q;
    tmg_t act_q;
    cfg_t cfg_q;

    logic htot_ok;
    logic vtot_ok;

    assign htot_ok = (wr_data[0] == 1'b0) && (wr_data != '0);
    assign vtot_ok = (wr_data != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= RST_TMG;
            act_q  <= RST_TMG;
            cfg_q  <= RST_CFG;
        end else begin
            if (frame_end) begin
                act_q <= pend_q;
            end
            if (wr_en) begin
                case (wr_addr)
                    ADR_CFG:    cfg_q         <= cfg_t'(wr_data[CFG_W-1:0]);
                    ADR_H_FP:   pend_q.h.fp   <= wr_data;
                    ADR_H_SE:   pend_q.h.se   <= wr_data;
                    ADR_H_BW:   pend_q.h.bw   <= wr_data;
                    ADR_H_TOT:  if (htot_ok) pend_q.h.tot <= wr_data;
                    ADR_V_FP:   pend_q.v.fp   <= wr_data;
                    ADR_V_SE:   pend_q.v.se   <= wr_data;
                    ADR_V_BW:   pend_q.v.bw   <= wr_data;
                    ADR_V_TOT:  if (vtot_ok) pend_q.v.tot <= wr_data;
                    ADR_VI_ON:  pend_q.vi_on  <= wr_data;
                    ADR_VI_OFF: pend_q.vi_off <= wr_data;
                    ADR_CUR_HS: pend_q.cur_hs <= wr_data;
                    ADR_CUR_HE: pend_q.cur_he <= wr_data;
                    ADR_CUR_VS: pend_q.cur_vs <= wr_data;
                    ADR_CUR_VE: pend_q.cur_ve <= wr_data;
                    default: ;
                endcase
            end
        end
    end

    assign act = act_q;
    assign cfg = cfg_q;

endmodule

// File: rtl/rtg_counters.sv
module rtg_counters
    import rtg_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  en,
    input  tval_t htot,
    input  tval_t vtot,
    output tval_t hpos,
    output tval_t vpos,
    output logic  frame_end
);

    tval_t h_q;
    tval_t v_q;
    logic  line_end;

    assign line_end  = en && (h_q == htot);
    assign frame_end = line_end && (v_q == vtot);

    always_ff @(posedge clk) begin
        if (rst) begin
            h_q <= TW'(1);
            v_q <= TW'(1);
        end else if (en) begin
            if (line_end) begin
                h_q <= TW'(1);
                v_q <= (v_q == vtot) ? TW'(1) : v_q + TW'(1);
            end else begin
                h_q <= h_q + TW'(1);
            end
        end
    end

    assign hpos = h_q;
    assign vpos = v_q;

endmodule

// File: rtl/rtg_outputs.sv
module rtg_outputs
    import rtg_pkg::*;
(
    input  tmg_t            act,
    input  cfg_t            cfg,
    input  tval_t           hpos,
    input  tval_t           vpos,
    output logic [NPIN-1:0] pins
);

    raw_t            raw;
    logic [NPIN-1:0] routed;

    always_comb begin
        raw.hblank = (hpos <= act.h.bw);
        raw.hsync  = in_win(hpos, act.h.fp, act.h.se);
        raw.vblank = (vpos <= act.v.bw);
        raw.vsync  = in_win(vpos, act.v.fp, act.v.se);
        raw.cblank = raw.hblank | raw.vblank;
        raw.csync  = raw.hsync | raw.vsync;
        raw.hgate  = in_win(hpos, act.cur_hs, act.cur_he);
        raw.vgate  = in_win(vpos, act.cur_vs, act.cur_ve);
        raw.cursor = raw.hgate & raw.vgate;
        raw.vint   = in_win(vpos, act.vi_on, act.vi_off);
    end

    // routed[0]=A, [1]=B, [2]=C, [3]=D
    always_comb begin
        routed[0] = cfg.sel[0] ? raw.vblank : raw.cblank;
        routed[1] = cfg.sel[1] ? raw.vsync  : raw.csync;
        case ({cfg.sel[2], cfg.sel[0]})
            2'b00:   routed[2] = raw.hgate;
            2'b10:   routed[2] = raw.cursor;
            default: routed[2] = raw.hblank;
        endcase
        case ({cfg.sel[2], cfg.sel[1]})
            2'b00:   routed[3] = raw.vgate;
            2'b10:   routed[3] = raw.vint;
            default: routed[3] = raw.hsync;
        endcase
    end

    for (genvar i = 0; i < NPIN; i++) begin : g_pol
        assign pins[i] = cfg.pol[i] ? routed[i] : ~routed[i];
    end

endmodule

// File: rtl/rtg_sync_gen.sv
module rtg_sync_gen
    import rtg_pkg::*;
#(
    parameter int H_FP    = 2,
    parameter int H_SE    = 5,
    parameter int H_BW    = 8,
    parameter int H_TOT   = 20,
    parameter int V_FP    = 1,
    parameter int V_SE    = 3,
    parameter int V_BW    = 4,
    parameter int V_TOT   = 12,
    parameter int VI_ON   = 2,
    parameter int VI_OFF  = 3,
    parameter int CUR_HS  = 10,
    parameter int CUR_HE  = 14,
    parameter int CUR_VS  = 5,
    parameter int CUR_VE  = 8,
    parameter bit CLK_EN0 = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [TW-1:0] wr_data,
    output logic          pin_a,
    output logic          pin_b,
    output logic          pin_c,
    output logic          pin_d,
    output logic [TW-1:0] h_pos,
    output logic [TW-1:0] v_pos
);

    localparam tmg_t RST_TMG = '{
        h:      '{fp: TW'(H_FP), se: TW'(H_SE), bw: TW'(H_BW), tot: TW'(H_TOT)},
        v:      '{fp: TW'(V_FP), se: TW'(V_SE), bw: TW'(V_BW), tot: TW'(V_TOT)},
        vi_on:  TW'(VI_ON),
        vi_off: TW'(VI_OFF),
        cur_hs: TW'(CUR_HS),
        cur_he: TW'(CUR_HE),
        cur_vs: TW'(CUR_VS),
        cur_ve: TW'(CUR_VE)
    };
    localparam cfg_t RST_CFG = '{en: CLK_EN0, pol: '0, sel: '0};

    tmg_t            act_tmg;
    cfg_t            cfg_q;
    logic            frame_end;
    logic [NPIN-1:0] pins;

    rtg_regs #(
        .RST_TMG (RST_TMG),
        .RST_CFG (RST_CFG)
    ) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .frame_end (frame_end),
        .act       (act_tmg),
        .cfg       (cfg_q)
    );

    rtg_counters u_cnt (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_q.en),
        .htot      (act_tmg.h.tot),
        .vtot      (act_tmg.v.tot),
        .hpos      (h_pos),
        .vpos      (v_pos),
        .frame_end (frame_end)
    );

    rtg_outputs u_out (
        .act  (act_tmg),
        .cfg  (cfg_q),
        .hpos (h_pos),
        .vpos (v_pos),
        .pins (pins)
    );

    assign pin_a = pins[0];
    assign pin_b = pins[1];
    assign pin_c = pins[2];
    assign pin_d = pins[3];

endmodule

// File: rtl/rtg_sync_gen_chk.sv
module rtg_sync_gen_chk
    import rtg_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input tval_t h_pos,
    input tval_t v_pos,
    input tmg_t  act,
    input cfg_t  cfg
);

    logic at_frame_end;
    assign at_frame_end = cfg.en && (h_pos == act.h.tot) && (v_pos == act.v.tot);

    // R1
    hpos_range_chk: assert property (@(posedge clk) disable iff (rst)
        (h_pos >= TW'(1)) && (h_pos <= act.h.tot));

    // R1
    vpos_range_chk: assert property (@(posedge clk) disable iff (rst)
        (v_pos >= TW'(1)) && (v_pos <= act.v.tot));

    // R1
    hpos_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && (h_pos != act.h.tot)) |=> (h_pos == $past(h_pos) + TW'(1)));

    // R1
    hpos_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.en && (h_pos == act.h.tot)) |=> (h_pos == TW'(1)));

    // R2
    htot_even_chk: assert property (@(posedge clk) disable iff (rst)
        (act.h.tot[0] == 1'b0) && (act.h.tot != '0));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> ($stable(h_pos) && $stable(v_pos)));

    // R9
    shadow_chk: assert property (@(posedge clk) disable iff (rst)
        !at_frame_end |=> $stable(act));

endmodule

bind rtg_sync_gen rtg_sync_gen_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .h_pos (h_pos),
    .v_pos (v_pos),
    .act   (act_tmg),
    .cfg   (cfg_q)
);

// File: tb/test_rtg_sync_gen.sv
module test_rtg_sync_gen;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [11:0] wr_data = '0;
    logic        pin_a, pin_b, pin_c, pin_d;
    logic [11:0] h_pos, v_pos;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtg_sync_gen i_rtg_sync_gen (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pin_a   (pin_a),
        .pin_b   (pin_b),
        .pin_c   (pin_c),
        .pin_d   (pin_d),
        .h_pos   (h_pos),
        .v_pos   (v_pos)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 0;
    string phase = "R10 reset";

    int act [0:18];
    int pend[0:18];
    int hc, vc;
    int m_sel, m_pol, m_en;

    function automatic bit win(int p, int s, int e);
        return (p > s) && (p <= e);
    endfunction

    task automatic model_reset();
        for (int i = 0; i <= 18; i++) pend[i] = 0;
        pend[1] = 2;   pend[2] = 5;   pend[3] = 8;   pend[4] = 20;
        pend[5] = 1;   pend[6] = 3;   pend[7] = 4;   pend[8] = 12;
        pend[13] = 2;  pend[14] = 3;
        pend[15] = 10; pend[16] = 14; pend[17] = 5;  pend[18] = 8;
        for (int i = 0; i <= 18; i++) act[i] = pend[i];
        hc = 1; vc = 1;
        m_sel = 0; m_pol = 0; m_en = 1;
    endtask

    task automatic model_step(bit we, int addr, int data);
        bit fe;
        fe = (m_en != 0) && hc == act[4] && vc == act[8];
        if (m_en != 0) begin
            if (hc == act[4]) begin
                hc = 1;
                vc = (vc == act[8]) ? 1 : vc + 1;
            end else begin
                hc = hc + 1;
            end
        end
        if (fe) for (int i = 0; i <= 18; i++) act[i] = pend[i];
        if (we) begin
            if (addr == 0) begin
                m_sel = data & 7;
                m_pol = (data >> 3) & 15;
                m_en  = (data >> 7) & 1;
            end else if (addr == 4) begin
                if (data % 2 == 0 && data != 0) pend[4] = data;
            end else if (addr == 8) begin
                if (data != 0) pend[8] = data;
            end else if ((addr >= 1 && addr <= 7) || (addr >= 13 && addr <= 18)) begin
                pend[addr] = data;
            end
        end
    endtask

    function automatic logic [3:0] model_pins();
        bit hb, hs, vb, vs, cb, cs, hg, vg, cur, vi;
        logic [3:0] r;
        hb  = hc <= act[3];
        hs  = win(hc, act[1], act[2]);
        vb  = vc <= act[7];
        vs  = win(vc, act[5], act[6]);
        cb  = hb | vb;
        cs  = hs | vs;
        hg  = win(hc, act[15], act[16]);
        vg  = win(vc, act[17], act[18]);
        cur = hg & vg;
        vi  = win(vc, act[13], act[14]);
        case (m_sel)
            0: r = {vg, hg, cs, cb};
            1: r = {vg, hb, cs, vb};
            2: r = {hs, hg, vs, cb};
            3: r = {hs, hb, vs, vb};
            4: r = {vi, cur, cs, cb};
            5: r = {vi, hb, cs, vb};
            6: r = {hs, cur, vs, cb};
            default: r = {hs, hb, vs, vb};
        endcase
        for (int i = 0; i < 4; i++) if (((m_pol >> i) & 1) == 0) r[i] = ~r[i];
        return r;
    endfunction

    task automatic compare();
        logic [3:0] exp_p, got_p;
        bit bad;
        bad   = 0;
        exp_p = model_pins();
        got_p = {pin_d, pin_c, pin_b, pin_a};
        n_vec++;
        if (int'(h_pos) != hc) begin
            $display("FAIL R1 [%s] h_pos got %0d exp %0d", phase, h_pos, hc); bad = 1;
        end
        if (int'(v_pos) != vc) begin
            $display("FAIL R1 [%s] v_pos got %0d exp %0d", phase, v_pos, vc); bad = 1;
        end
        for (int i = 0; i < 4; i++) begin
            if (got_p[i] !== exp_p[i]) begin
                $display("FAIL R5 R6 [%s] pin %0d at h=%0d v=%0d got %b exp %b",
                         phase, i, hc, vc, got_p[i], exp_p[i]);
                bad = 1;
            end
        end
        if (bad) n_bad++;
    endtask

    task automatic tick(bit we, int addr, int data);
        wr_en   = we;
        wr_addr = 5'(addr);
        wr_data = 12'(data);
        @(posedge clk);
        model_step(we, addr, data);
        @(negedge clk);
        wr_en = 1'b0;
        compare();
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) tick(0, 0, 0);
    endtask

    task automatic wr(int addr, int data);
        tick(1, addr, data);
    endtask

    function automatic int cfgw(int en, int pol, int sel);
        return (en << 7) | (pol << 3) | sel;
    endfunction

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state at the ports
        compare();

        phase = "R1 R3 R4 default frame";
        run(2 * 240 + 5);

        // R9: new timing lands only at the frame boundary
        phase = "R9 shadow load";
        run(37);
        wr(1, 1); wr(2, 3); wr(3, 4); wr(4, 10);
        wr(5, 1); wr(6, 2); wr(7, 3); wr(8, 6);
        wr(15, 3); wr(16, 7); wr(17, 1); wr(18, 4);
        wr(13, 2); wr(14, 5);
        run(300);

        // R2: odd or zero totals dropped
        phase = "R2 rejected totals";
        wr(4, 11); wr(4, 0); wr(8, 0);
        run(150);

        // R5 R6: every select code with varying polarity
        for (int s = 0; s < 8; s++) begin
            phase = $sformatf("R5 R6 sel %0d", s);
            wr(0, cfgw(1, (s * 5 + 3) % 16, s));
            run(65);
        end

        // R8: cursor, gates and vertical interrupt windows
        phase = "R8 windows";
        wr(0, cfgw(1, 15, 4));
        run(130);
        wr(0, cfgw(1, 15, 0));
        run(65);

        // R7: counters hold with clock enable low
        phase = "R7 hold";
        wr(0, cfgw(0, 15, 3));
        run(40);
        wr(0, cfgw(1, 15, 3));
        run(40);

        // R11: unused addresses change nothing
        phase = "R11 unused address";
        wr(10, 4095); wr(31, 7); wr(19, 1);
        run(130);

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            $display("FAIL watchdog expired in phase [%s]", phase);
            n_bad++;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule